// File: doc/BRIEF.md
# Fractional Millisecond Tick Generator

This block turns a stream of 32,768 Hz tick strobes into a once-per-millisecond strobe and a running millisecond count. A millisecond spans 32.768 low-speed ticks, which is not a whole number. The block therefore ends each millisecond after either 32 or 33 ticks. A small fractional accumulator picks the length of each interval so that the long-run rate is exactly one pulse per 32.768 ticks and the rounding error never builds up.

The block runs on a fast system clock. The low-speed tick arrives as a strobe that is one system clock wide and has any number of idle cycles between strobes. Only cycles that carry a strobe advance the interval. The output strobe is combinational on the tick strobe that ends an interval, so it appears in that same system-clock cycle. The millisecond count is a registered value that wraps when it overflows.

Top module: `ms_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the interval tick count, the fractional accumulator and `ms_count` return to zero. The first interval after reset is 32 ticks long.
- R2: `ms_pulse` is high for exactly the system-clock cycles whose `tick_in` strobe completes an interval. It is never high in a cycle where `tick_in` is low.
- R3: Each interval is either 32 or 33 ticks long. At each pulse the accumulator gains 96. If the sum is 125 or more, 125 is taken off and the next interval is 33 ticks; otherwise the next interval is 32 ticks.
- R4: The n-th pulse after reset falls on tick number 32·n + floor(96·(n−1)/125), with ticks counted from 1 after reset.
- R5: Any 125 consecutive pulses end on ticks exactly 4096 apart.
- R6: `ms_count` goes up by one in the cycle after each pulse and holds in every other cycle. It wraps modulo 2^CNT_W (default 32 bits).
- R7: After every update the fractional accumulator holds a value from 0 to 124.
- R8: Idle system-clock cycles between tick strobes, in any number, do not change when the pulse occurs in the tick sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | One-cycle strobe for each 32,768 Hz tick |
| ms_pulse | output | 1 | One-cycle millisecond strobe, aligned with the completing tick |
| ms_count | output | CNT_W | Running millisecond count, wraps on overflow |

## Verification
`ms_pulse` is expected in the same cycle as the completing `tick_in`. The bench sets each input shortly after a falling edge and reads the strobe one time unit later, before the next rising edge. `ms_count` is expected one rising edge after a pulse, so the bench compares it with a reference value that it advances only after that cycle's comparison. The tick position of each pulse is checked against the closed-form formula and against a 125-pulse sliding window. Random idle gaps between strobes show that only tick cycles move the result.

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int unsigned BASE  = 32,
  parameter int unsigned NUM   = 96,
  parameter int unsigned DEN   = 125,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  output logic             ms_pulse,
  output logic [CNT_W-1:0] ms_count
);
  localparam int TW = $clog2(BASE + 1);
  localparam int AW = $clog2(DEN);
  localparam int SW = $clog2(DEN + NUM);
  localparam logic [TW-1:0] LAST_SHORT = TW'(BASE - 1);
  localparam logic [TW-1:0] LAST_LONG  = TW'(BASE);

  logic [TW-1:0] tcnt_q;
  logic [AW-1:0] acc_q;
  logic          long_q;
  logic [SW-1:0] sum;
  logic          wrap;

  assign ms_pulse = tick_in && (tcnt_q == (long_q ? LAST_LONG : LAST_SHORT));
  assign sum      = SW'(acc_q) + SW'(NUM);
  assign wrap     = sum >= SW'(DEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q   <= '0;
      acc_q    <= '0;
      long_q   <= 1'b0;
      ms_count <= '0;
    end else if (tick_in) begin
      if (ms_pulse) begin
        tcnt_q   <= '0;
        acc_q    <= wrap ? AW'(sum - SW'(DEN)) : AW'(sum);
        long_q   <= wrap;
        ms_count <= ms_count + 1'b1;
      end else begin
        tcnt_q   <= tcnt_q + 1'b1;
      end
    end
  end

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(acc_q) < DEN); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ms_pulse |=> ms_count == $past(ms_count) + 1'b1); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ms_pulse |=> $stable(ms_count)); // R6
  AST_INTERVAL_RESTART: assert property (@(posedge clk) disable iff (rst)
    ms_pulse |=> tcnt_q == '0); // R3
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(tcnt_q) <= BASE); // R3
endmodule

// File: tb/tb_ms_tick_gen.sv
module tb_ms_tick_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_in;
  logic        ms_pulse, ms_pulse_w;
  logic [31:0] ms_count;
  logic [7:0]  ms_count_w;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  longint m_cnt, tick_total, pulse_n, last_total;
  int     m_tcnt, m_acc;
  bit     m_long;
  longint hist [0:125];

  always #(CLK_P/2) clk = ~clk;

  ms_tick_gen dut (.clk(clk), .rst(rst), .tick_in(tick_in),
                   .ms_pulse(ms_pulse), .ms_count(ms_count));
  ms_tick_gen #(.CNT_W(8)) dut_w (.clk(clk), .rst(rst), .tick_in(tick_in),
                   .ms_pulse(ms_pulse_w), .ms_count(ms_count_w));

  function automatic longint exp_ticks(longint n);
    return 32*n + (96*(n-1))/125;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; tick_total = 0; pulse_n = 0; last_total = 0;
    m_tcnt = 0; m_acc = 0; m_long = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick_in = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R1: reset state at the ports
    chk(ms_count == 0, "R1 count", ms_count, 0);
    chk(ms_count_w == 0, "R1 count_w", ms_count_w, 0);
    chk(ms_pulse == 1'b0, "R1 pulse", ms_pulse, 0);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic step(bit t);
    bit exp_p;
    int s;
    tick_in = t;
    #1;
    exp_p = t && (m_tcnt == (m_long ? 32 : 31));
    chk(ms_pulse == exp_p, "R2 pulse", ms_pulse, exp_p);   // R8 idle cycles never pulse
    chk(ms_pulse_w == exp_p, "R2 pulse_w", ms_pulse_w, exp_p);
    chk(ms_count == 32'(m_cnt), "R6 count", ms_count, 32'(m_cnt));
    chk(ms_count_w == 8'(m_cnt), "R6 wrap", ms_count_w, 8'(m_cnt));
    if (t) begin
      tick_total++;
      if (exp_p) begin
        pulse_n++;
        // R1 (n=1 gives 32) and R4 closed form
        chk(tick_total == exp_ticks(pulse_n), "R4 position", tick_total, exp_ticks(pulse_n));
        chk((tick_total - last_total == 32) || (tick_total - last_total == 33),
            "R3 interval", tick_total - last_total, 32);
        last_total = tick_total;
        hist[pulse_n % 126] = tick_total;
        if (pulse_n > 125)
          chk(tick_total - hist[(pulse_n - 125) % 126] == 4096, "R5 window",
              tick_total - hist[(pulse_n - 125) % 126], 4096);
        m_cnt++;
        m_tcnt = 0;
        s = m_acc + 96;
        if (s >= 125) begin m_acc = s - 125; m_long = 1'b1; end
        else          begin m_acc = s;       m_long = 1'b0; end
      end else begin
        m_tcnt++;
      end
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    rst = 1'b1; tick_in = 1'b0;
    @(negedge clk);
    do_reset();
    // directed: back-to-back ticks, R3/R4 pattern 32,32,33,33,33,32
    for (int i = 0; i < 300; i++) step(1'b1);
    // R8: random idle gaps between ticks
    for (int i = 0; i < 20000; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) step(1'b0);
      step(1'b1);
    end
    chk(pulse_n > 256, "R6 wrap reached", pulse_n, 257);
    // R1: reset in mid-run restarts the sequence
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) step(1'b0);
      step(1'b1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule